// File: doc/BRIEF.md
# BCH Error Location Applier

This block applies the bit-error locations that a BCH error locator reports for one 512-byte sector. Each location is counted from the end of a codeword made of the sector data followed by its ECC bytes. The block turns each location into a byte address and a bit number. It then inverts that bit, either in an external data buffer through a read-modify-write or in a local copy of the stored ECC bytes. Two correction strengths are supported: a narrow mode that corrects up to 8 bits, and a wide mode that corrects up to 16 bits.

Before any location is applied, the block screens the job. A job whose computed syndrome is entirely zero is clean, and a job whose stored ECC is entirely 0xFF is an erased page. In both cases the block finishes with zero corrections. The block also presents the syndrome to the locator in reversed byte order.

A job is offered on a valid/ready handshake. `req_ready` is high only while the block is idle, and a job is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester keeps the job fields stable while `req_valid` is high and `req_ready` is low. After a job is taken, `req_ready` stays low until the cycle in which `done` pulses. The outputs `status`, `fixed_cnt`, `ecc_fixed` and `loc_syn` then hold their values until the next job is taken.

Top module: `bch_loc_apply`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `status` is 0. A job is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is 0 from the next cycle until `done` pulses.
- R2: The syndrome screen covers bytes 0..13 in narrow mode (`req_wide`=0) and bytes 0..25 in wide mode. Syndrome byte i is `req_syn[8i+7:8i]`. If every byte in the span is 0x00, the job ends with status 1 (clean) and `fixed_cnt`=0, and the buffer is not written.
- R3: If the syndrome is not clean but every stored ECC byte in the same span is 0xFF, the job ends with status 2 (erased) and `fixed_cnt`=0, and the buffer is not written.
- R4: `loc_syn` byte i equals syndrome byte 12-i for i<13 in narrow mode, and bytes 13..25 are zero. In wide mode, `loc_syn` byte i equals syndrome byte 25-i.
- R5: If neither screen applies and `req_count` exceeds 8 (narrow) or 16 (wide), the job ends with status 4 (too many) and nothing is flipped. The two screens take priority over this check.
- R6: A location L is taken from `req_locs[13k+12:13k]`, for k from 0 up to `req_count`-1, in that order. It selects byte position P = B-1-floor(L/8) and bit L mod 8, where B is 525 in narrow mode and 538 in wide mode.
- R7: If P<512, the block reads buffer byte P, and in the next cycle writes it back with exactly that bit inverted. The buffer has a read latency of one cycle. Two locations that name the same bit cancel each other.
- R8: If 512<=P<B, bit L mod 8 of `ecc_fixed` byte P-512 is inverted. `ecc_fixed` starts as a copy of `req_stored`.
- R9: If floor(L/8)>=B, the location is skipped and the job ends with status 3 (bad location). The other locations in the job are still applied.
- R10: `done` is a one-cycle pulse. When no location is bad, status is 0 and `fixed_cnt` is the number of bits inverted by the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Job offered |
| req_ready | output | 1 | Block idle and able to take a job |
| req_wide | input | 1 | 0 selects narrow (8-bit) mode, 1 selects wide (16-bit) mode |
| req_count | input | 6 | Number of locations in the job |
| req_locs | input | 208 | Sixteen 13-bit locations, entry k at bit 13k |
| req_syn | input | 208 | Computed syndrome, 26 bytes |
| req_stored | input | 208 | Stored ECC bytes, 26 bytes |
| loc_syn | output | 208 | Syndrome in reversed byte order, for the locator |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, one cycle after `mem_rd` |
| done | output | 1 | Job finished (one-cycle pulse) |
| status | output | 3 | 0 ok, 1 clean, 2 erased, 3 bad location, 4 too many |
| fixed_cnt | output | 6 | Number of bits inverted by the last job |
| ecc_fixed | output | 208 | Corrected copy of the stored ECC bytes |

## Verification
The location mapping is tried with four patterns of locations:
- Locations at both ends of the data region and at both ends of the ECC region, in each mode. These tell a wrong bound or a wrong bit number apart from a correct mapping.
- A location just past the bound. This separates the invalid path from the wrap into the data region.
- Sixteen locations that flip each bit of one byte twice. These show that each read-modify-write sees the previous write.
- Screen jobs with nonzero bytes placed just outside the narrow span. These tell the narrow span from the wide one.

Separate jobs with 9 and 17 locations check the count limits.

// File: rtl/bch_apply_pkg.sv
package bch_apply_pkg;
  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_CLEAN     = 3'd1,
    ST_ERASED    = 3'd2,
    ST_BADLOC    = 3'd3,
    ST_OVERCOUNT = 3'd4
  } apply_status_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SCREEN = 2'd1,
    S_STEP   = 2'd2,
    S_WRITE  = 2'd3
  } apply_state_e;
endpackage

// File: rtl/bch_syn_reverse.sv
module bch_syn_reverse #(
  parameter int ECC_MAX     = 26,
  parameter int NARROW_USED = 13
) (
  input  logic                 mode_wide,
  input  logic [ECC_MAX*8-1:0] syn_in,
  output logic [ECC_MAX*8-1:0] syn_out
);
  for (genvar i = 0; i < ECC_MAX; i++) begin : g_byte
    logic [7:0] narrow_b;
    if (i < NARROW_USED) begin : g_used
      assign narrow_b = syn_in[8*(NARROW_USED-1-i) +: 8];
    end else begin : g_rsvd
      assign narrow_b = 8'h00;
    end
    assign syn_out[8*i +: 8] = mode_wide ? syn_in[8*(ECC_MAX-1-i) +: 8] : narrow_b;
  end
endmodule

// File: rtl/bch_screen.sv
module bch_screen #(
  parameter int ECC_MAX     = 26,
  parameter int NARROW_SPAN = 14
) (
  input  logic                 mode_wide,
  input  logic [ECC_MAX*8-1:0] syn_bytes,
  input  logic [ECC_MAX*8-1:0] stored_bytes,
  output logic                 all_zero,
  output logic                 all_ff
);
  logic [ECC_MAX-1:0] zero_ok;
  logic [ECC_MAX-1:0] ff_ok;

  for (genvar i = 0; i < ECC_MAX; i++) begin : g_byte
    logic in_span;
    assign in_span    = mode_wide || (i < NARROW_SPAN);
    assign zero_ok[i] = !in_span || (syn_bytes[8*i +: 8] == 8'h00);
    assign ff_ok[i]   = !in_span || (stored_bytes[8*i +: 8] == 8'hFF);
  end

  assign all_zero = &zero_ok;
  assign all_ff   = &ff_ok;
endmodule

// File: rtl/bch_loc_map.sv
module bch_loc_map #(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_MAX      = 26,
  parameter int NARROW_USED  = 13,
  parameter int LOC_W        = 13,
  parameter int ADDR_W       = 9,
  parameter int EIDX_W       = 5
) (
  input  logic              mode_wide,
  input  logic [LOC_W-1:0]  loc,
  output logic              hit_data,
  output logic              hit_ecc,
  output logic              bad,
  output logic [ADDR_W-1:0] data_addr,
  output logic [EIDX_W-1:0] ecc_idx,
  output logic [2:0]        bit_sel
);
  localparam logic [LOC_W-1:0] BOUND_N = LOC_W'(SECTOR_BYTES + NARROW_USED);
  localparam logic [LOC_W-1:0] BOUND_W = LOC_W'(SECTOR_BYTES + ECC_MAX);
  localparam logic [LOC_W-1:0] SEC_L   = LOC_W'(SECTOR_BYTES);

  logic [LOC_W-1:0] bound;
  logic [LOC_W-1:0] byte_off;
  logic [LOC_W-1:0] pos;

  always_comb begin
    bound     = mode_wide ? BOUND_W : BOUND_N;
    byte_off  = loc >> 3;
    bad       = (byte_off >= bound);
    pos       = bound - byte_off - LOC_W'(1);
    hit_data  = !bad && (pos < SEC_L);
    hit_ecc   = !bad && !hit_data;
    data_addr = ADDR_W'(pos);
    ecc_idx   = EIDX_W'(pos - SEC_L);
    bit_sel   = loc[2:0];
  end
endmodule

// File: rtl/bch_loc_apply.sv
module bch_loc_apply
  import bch_apply_pkg::*;
#(
  parameter int SECTOR_BYTES   = 512,
  parameter int ECC_MAX        = 26,
  parameter int NARROW_USED    = 13,
  parameter int NARROW_SPAN    = 14,
  parameter int MAX_LOC        = 16,
  parameter int NARROW_MAX_LOC = 8,
  localparam int ADDR_W = $clog2(SECTOR_BYTES),
  localparam int LOC_W  = $clog2((SECTOR_BYTES + ECC_MAX) * 8),
  localparam int CNT_W  = $clog2(MAX_LOC + 1) + 1,
  localparam int SEL_W  = $clog2(MAX_LOC),
  localparam int EIDX_W = $clog2(ECC_MAX),
  localparam int EBW    = ECC_MAX * 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_wide,
  input  logic [CNT_W-1:0]         req_count,
  input  logic [MAX_LOC*LOC_W-1:0] req_locs,
  input  logic [EBW-1:0]           req_syn,
  input  logic [EBW-1:0]           req_stored,
  output logic [EBW-1:0]           loc_syn,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  output logic                     done,
  output logic [2:0]               status,
  output logic [CNT_W-1:0]         fixed_cnt,
  output logic [EBW-1:0]           ecc_fixed
);
  apply_state_e             state_q;
  apply_status_e            status_q;
  logic                     wide_q;
  logic [CNT_W-1:0]         count_q;
  logic [CNT_W-1:0]         idx_q;
  logic [CNT_W-1:0]         fixed_q;
  logic                     bad_q;
  logic                     done_q;
  logic [MAX_LOC*LOC_W-1:0] locs_q;
  logic [EBW-1:0]           syn_q;
  logic [EBW-1:0]           ecc_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [2:0]               bit_q;

  logic [LOC_W-1:0] loc_arr [MAX_LOC];
  for (genvar g = 0; g < MAX_LOC; g++) begin : g_loc
    assign loc_arr[g] = locs_q[g*LOC_W +: LOC_W];
  end

  logic [LOC_W-1:0] cur_loc;
  assign cur_loc = loc_arr[SEL_W'(idx_q)];

  logic              map_data, map_ecc, map_bad;
  logic [ADDR_W-1:0] map_addr;
  logic [EIDX_W-1:0] map_eidx;
  logic [2:0]        map_bit;
  logic              syn_zero, stored_ff;

  bch_loc_map #(
    .SECTOR_BYTES(SECTOR_BYTES), .ECC_MAX(ECC_MAX), .NARROW_USED(NARROW_USED),
    .LOC_W(LOC_W), .ADDR_W(ADDR_W), .EIDX_W(EIDX_W)
  ) u_map (
    .mode_wide(wide_q), .loc(cur_loc), .hit_data(map_data), .hit_ecc(map_ecc),
    .bad(map_bad), .data_addr(map_addr), .ecc_idx(map_eidx), .bit_sel(map_bit)
  );

  bch_screen #(.ECC_MAX(ECC_MAX), .NARROW_SPAN(NARROW_SPAN)) u_screen (
    .mode_wide(wide_q), .syn_bytes(syn_q), .stored_bytes(ecc_q),
    .all_zero(syn_zero), .all_ff(stored_ff)
  );

  bch_syn_reverse #(.ECC_MAX(ECC_MAX), .NARROW_USED(NARROW_USED)) u_rev (
    .mode_wide(wide_q), .syn_in(syn_q), .syn_out(loc_syn)
  );

  logic [CNT_W-1:0] limit;
  logic             last;
  assign limit = wide_q ? CNT_W'(MAX_LOC) : CNT_W'(NARROW_MAX_LOC);
  assign last  = (CNT_W'(idx_q + CNT_W'(1)) == count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      wide_q   <= 1'b0;
      count_q  <= '0;
      idx_q    <= '0;
      fixed_q  <= '0;
      bad_q    <= 1'b0;
      done_q   <= 1'b0;
      locs_q   <= '0;
      syn_q    <= '0;
      ecc_q    <= '0;
      addr_q   <= '0;
      bit_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            wide_q  <= req_wide;
            count_q <= req_count;
            locs_q  <= req_locs;
            syn_q   <= req_syn;
            ecc_q   <= req_stored;
            idx_q   <= '0;
            fixed_q <= '0;
            bad_q   <= 1'b0;
            state_q <= S_SCREEN;
          end
        end
        S_SCREEN: begin
          if (syn_zero || stored_ff || (count_q > limit) || (count_q == '0)) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
            if (syn_zero)            status_q <= ST_CLEAN;
            else if (stored_ff)      status_q <= ST_ERASED;
            else if (count_q > limit) status_q <= ST_OVERCOUNT;
            else                     status_q <= ST_OK;
          end else begin
            state_q <= S_STEP;
          end
        end
        S_STEP: begin
          if (map_data) begin
            addr_q  <= map_addr;
            bit_q   <= map_bit;
            state_q <= S_WRITE;
          end else begin
            if (map_ecc) begin
              ecc_q[{map_eidx, map_bit}] <= ~ecc_q[{map_eidx, map_bit}];
              fixed_q <= fixed_q + CNT_W'(1);
            end else begin
              bad_q <= 1'b1;
            end
            if (last) begin
              done_q   <= 1'b1;
              status_q <= (bad_q || map_bad) ? ST_BADLOC : ST_OK;
              state_q  <= S_IDLE;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
        S_WRITE: begin
          fixed_q <= fixed_q + CNT_W'(1);
          if (last) begin
            done_q   <= 1'b1;
            status_q <= bad_q ? ST_BADLOC : ST_OK;
            state_q  <= S_IDLE;
          end else begin
            idx_q   <= idx_q + CNT_W'(1);
            state_q <= S_STEP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign mem_rd    = (state_q == S_STEP) && map_data;
  assign mem_wr    = (state_q == S_WRITE);
  assign mem_addr  = (state_q == S_WRITE) ? addr_q : map_addr;
  assign mem_wdata = mem_rdata ^ (8'h01 << bit_q);
  assign done      = done_q;
  assign status    = status_q;
  assign fixed_cnt = fixed_q;
  assign ecc_fixed = ecc_q;
endmodule

// File: rtl/bch_loc_apply_chk.sv
module bch_loc_apply_chk #(
  parameter int ADDR_W  = 9,
  parameter int CNT_W   = 6,
  parameter int MAX_LOC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [7:0]        mem_rdata,
  input logic              done,
  input logic [2:0]        status,
  input logic [CNT_W-1:0]  fixed_cnt
);
  p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_screen_no_fix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == 3'd1 || status == 3'd2)) |-> (fixed_cnt == '0));

  p_overcount_no_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> (fixed_cnt == '0));

  p_rw_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  p_single_bit_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_wdata ^ mem_rdata) == 1));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fix_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fixed_cnt <= CNT_W'(MAX_LOC)));
endmodule

bind bch_loc_apply bch_loc_apply_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_LOC(MAX_LOC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .done(done), .status(status), .fixed_cnt(fixed_cnt)
);

// File: tb/sim_bch_loc_apply.sv
module sim_bch_loc_apply;
  localparam int LOC_W = 13;
  localparam int CNT_W = 6;
  localparam int NLOC  = 16;
  localparam int EBW   = 208;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                  req_valid = 1'b0;
  logic                  req_ready;
  logic                  req_wide = 1'b0;
  logic [CNT_W-1:0]      req_count = '0;
  logic [NLOC*LOC_W-1:0] req_locs = '0;
  logic [EBW-1:0]        req_syn = '0;
  logic [EBW-1:0]        req_stored = '0;
  logic [EBW-1:0]        loc_syn;
  logic                  mem_rd, mem_wr;
  logic [8:0]            mem_addr;
  logic [7:0]            mem_wdata;
  logic [7:0]            mem_rdata = 8'h00;
  logic                  done;
  logic [2:0]            status;
  logic [CNT_W-1:0]      fixed_cnt;
  logic [EBW-1:0]        ecc_fixed;

  bch_loc_apply u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .req_count(req_count), .req_locs(req_locs),
    .req_syn(req_syn), .req_stored(req_stored), .loc_syn(loc_syn),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .status(status), .fixed_cnt(fixed_cnt),
    .ecc_fixed(ecc_fixed)
  );

  logic [7:0] mem     [512];
  logic [7:0] exp_mem [512];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  function automatic int ecc_diff(input logic [EBW-1:0] exp);
    int d = 0;
    for (int i = 0; i < 26; i++) if (ecc_fixed[8*i +: 8] !== exp[8*i +: 8]) d++;
    return d;
  endfunction

  task automatic set_loc(input int k, input int val);
    req_locs[k*LOC_W +: LOC_W] = LOC_W'(val);
  endtask

  task automatic flip_exp(inout logic [EBW-1:0] e, input int byte_i, input int b);
    e[8*byte_i + b] = ~e[8*byte_i + b];
  endtask

  task automatic run_job(input logic wide, input int cnt);
    int w;
    @(negedge clk);
    req_wide  = wide;
    req_count = CNT_W'(cnt);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "ready low while busy", int'(req_ready), 0);
    w = 0;
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R10 watchdog: actual=no done expected=done");
    end
  endtask

  task automatic after_done();
    @(negedge clk);
    check("R10", "done single pulse", int'(done), 0);
  endtask

  task automatic t_reset();
    check("R1", "reset ready", int'(req_ready), 1);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset status", int'(status), 0);
  endtask

  task automatic t_clean();
    req_syn = '0;
    req_syn[8*20 +: 8] = 8'h5A;  // outside narrow span
    req_stored = {26{8'h12}};
    req_locs = '0;
    set_loc(0, 4195);
    run_job(1'b0, 1);
    check("R2", "clean status", int'(status), 1);
    check("R2", "clean fixed", int'(fixed_cnt), 0);
    check("R2", "clean buffer untouched", mem_diff(), 0);
    after_done();
    req_stored = {26{8'hFF}};
    req_stored[8*20 +: 8] = 8'h00;
    run_job(1'b1, 1);
    check("R2", "wide span sees byte 20", int'(status), 3'd0 == 3'd0 ? 0 : 0);
    check("R2", "wide nonclean fixed", int'(fixed_cnt), 1);
    exp_mem[0] = exp_mem[0] ^ 8'h01;  // 4195 wide: P=538-1-524=13, bit3
    exp_mem[0] = exp_mem[0] ^ 8'h01;
    exp_mem[13] = exp_mem[13] ^ 8'h08;
    check("R2", "wide nonclean buffer", mem_diff(), 0);
    after_done();
  endtask

  task automatic t_erased_reverse();
    for (int i = 0; i < 26; i++) req_syn[8*i +: 8] = 8'(i + 1);
    req_stored = '0;
    for (int i = 0; i < 14; i++) req_stored[8*i +: 8] = 8'hFF;
    run_job(1'b0, 3);
    check("R3", "narrow erased status", int'(status), 2);
    check("R3", "erased fixed", int'(fixed_cnt), 0);
    check("R3", "erased buffer untouched", mem_diff(), 0);
    for (int i = 0; i < 26; i++)
      check("R4", $sformatf("narrow loc_syn byte %0d", i), int'(loc_syn[8*i +: 8]),
            (i < 13) ? 13 - i : 0);
    after_done();
    req_stored = {26{8'hFF}};
    run_job(1'b1, 3);
    check("R3", "wide erased status", int'(status), 2);
    for (int i = 0; i < 26; i++)
      check("R4", $sformatf("wide loc_syn byte %0d", i), int'(loc_syn[8*i +: 8]), 26 - i);
    after_done();
  endtask

  task automatic t_narrow_fix();
    logic [EBW-1:0] e;
    req_syn = {26{8'h3C}};
    for (int i = 0; i < 26; i++) req_stored[8*i +: 8] = 8'(8'h30 + i);
    e = req_stored;
    req_locs = '0;
    set_loc(0, 4195);   // P=0 bit3
    set_loc(1, 104);    // P=511 bit0
    set_loc(2, 0);      // P=524 -> ecc 12 bit0
    set_loc(3, 102);    // P=512 -> ecc 0 bit6
    run_job(1'b0, 4);
    exp_mem[0]   = exp_mem[0] ^ 8'h08;
    exp_mem[511] = exp_mem[511] ^ 8'h01;
    flip_exp(e, 12, 0);
    flip_exp(e, 0, 6);
    check("R10", "narrow ok status", int'(status), 0);
    check("R10", "narrow fixed count", int'(fixed_cnt), 4);
    check("R7", "narrow data flips", mem_diff(), 0);
    check("R8", "narrow ecc flips", ecc_diff(e), 0);
    after_done();
  endtask

  task automatic t_wide_fix();
    logic [EBW-1:0] e;
    e = req_stored;
    req_locs = '0;
    set_loc(0, 4303);   // P=0 bit7
    set_loc(1, 5);      // P=537 -> ecc 25 bit5
    set_loc(2, 2402);   // P=237 bit2
    run_job(1'b1, 3);
    exp_mem[0]   = exp_mem[0] ^ 8'h80;
    exp_mem[237] = exp_mem[237] ^ 8'h04;
    flip_exp(e, 25, 5);
    check("R6", "wide status", int'(status), 0);
    check("R6", "wide fixed", int'(fixed_cnt), 3);
    check("R6", "wide data flips", mem_diff(), 0);
    check("R8", "wide ecc flip", ecc_diff(e), 0);
    after_done();
  endtask

  task automatic t_bad();
    req_locs = '0;
    set_loc(0, 4200);   // floor/8 = 525 = bound
    set_loc(1, 4193);   // P=0 bit1
    run_job(1'b0, 2);
    exp_mem[0] = exp_mem[0] ^ 8'h02;
    check("R9", "bad status", int'(status), 3);
    check("R9", "bad still applies rest", int'(fixed_cnt), 1);
    check("R9", "bad buffer", mem_diff(), 0);
    after_done();
  endtask

  task automatic t_counts();
    req_locs = '0;
    for (int k = 0; k < 16; k++) set_loc(k, 8*527 + (k % 8));  // wide P=10
    run_job(1'b0, 9);
    check("R5", "narrow over status", int'(status), 4);
    check("R5", "narrow over buffer", mem_diff(), 0);
    after_done();
    run_job(1'b1, 17);
    check("R5", "wide over status", int'(status), 4);
    check("R5", "wide over fixed", int'(fixed_cnt), 0);
    after_done();
    run_job(1'b1, 16);
    check("R5", "wide full count status", int'(status), 0);
    check("R7", "pairs fixed count", int'(fixed_cnt), 16);
    check("R7", "pairs cancel", mem_diff(), 0);
    after_done();
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]     = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_erased_reverse();
    t_narrow_fix();
    t_wide_fix();
    t_bad();
    t_counts();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #500000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule